// File: doc/BRIEF.md
# Configurable LCD refresh scan controller

This block drives the continuous refresh of a monochrome dot-matrix LCD whose image lives in a framebuffer held in system RAM. Each clock it issues the next framebuffer byte address. The byte that the synchronous memory returns one cycle later goes to an 8-bit parallel column driver, qualified by a load strobe. When a line's worth of bytes has been sent, a row-shift clock pulse advances the row driver. The first row of every frame also carries a frame marker, so the row driver can resynchronise.

A configuration byte selects the line width and the frame height. The end of the last row raises a frame-done interrupt flag, and that flag doubles as the system's periodic tick: a shorter frame gives a faster tick. A geometry write is held back until the current frame ends, so no frame is drawn with two geometries. The interrupt flag stays set until software acknowledges it.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: While `rst_n` is low, `fb_addr` equals the base address `BASE` (default 16'hC000), and `col_load`, `row_clk`, `frame_mark` and `irq` are all low. The geometry after reset is 80 columns by 64 rows.
- R2: `cfg_data[4:3]` selects the line width: 00 = 80, 01 = 96, 10 = 128, 11 = 160 pixels, which is 10, 12, 16 or 20 bytes per line. `row_clk` is high for exactly one cycle per line, together with `col_load` of the last byte of that line.
- R3: One new address is issued per clock, and each address is the previous one plus one. The byte returned for an address is driven on `col_data` with `col_load` high in the cycle after that address was presented.
- R4: `cfg_data[2:1]` selects the frame height: 00 = 64, 01 = 32, 10 = 16, 11 = 85 rows. After the last byte of the last row, the next address issued is `BASE`.
- R5: `frame_mark` is high only together with the `row_clk` pulse of row 0, so exactly once per frame.
- R6: `irq` goes high in the cycle after the `row_clk` pulse of the last row. It stays high until a cycle in which `irq_ack` is sampled high. If a frame end and an acknowledge arrive in the same cycle, the flag stays set.
- R7: A write with `cfg_we` high changes the geometry only from the next frame start onward. The frame in progress finishes with the old geometry. Bits 7:5 and bit 0 of `cfg_data` have no effect.
- R8: With a steady geometry, consecutive rises of `irq` are bytes-per-line times rows cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration byte (bits 4:3 width, bits 2:1 height) |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| fb_rdata | input | 8 | Framebuffer byte, returned one cycle after its address |
| fb_addr | output | AW | Framebuffer byte address |
| col_data | output | 8 | Pixel byte for the column driver |
| col_load | output | 1 | Column driver load strobe |
| row_clk | output | 1 | Row-shift clock pulse at end of line |
| frame_mark | output | 1 | First-row marker, with row 0's row clock |
| irq | output | 1 | Frame-done interrupt flag |

## Verification
Each result has a fixed latency. The address moves on every clock edge. The byte for an address, together with its load strobe, the row clock and the frame marker, appears one edge after the address. The interrupt flag rises one edge after the last row clock, and it clears one edge after an acknowledge is sampled. The bench's reference model advances on the same edge the design uses, and the bench compares all outputs at the falling edge, half a cycle after they settle. Period, row-count and acknowledge checks count cycles between observed flag rises and drive strobes at the falling edge, so each strobe is sampled on exactly one rising edge.

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hC000,
  parameter int BYTE_W = 5,
  parameter int ROW_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_data,
  input  logic          irq_ack,
  input  logic [7:0]    fb_rdata,
  output logic [AW-1:0] fb_addr,
  output logic [7:0]    col_data,
  output logic          col_load,
  output logic          row_clk,
  output logic          frame_mark,
  output logic          irq
);

  function automatic logic [BYTE_W-1:0] last_byte(input logic [1:0] sel);
    case (sel)
      2'd0: last_byte = BYTE_W'(9);
      2'd1: last_byte = BYTE_W'(11);
      2'd2: last_byte = BYTE_W'(15);
      default: last_byte = BYTE_W'(19);
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] last_row(input logic [1:0] sel);
    case (sel)
      2'd0: last_row = ROW_W'(63);
      2'd1: last_row = ROW_W'(31);
      2'd2: last_row = ROW_W'(15);
      default: last_row = ROW_W'(84);
    endcase
  endfunction

  logic [1:0] pend_w, pend_h, act_w, act_h;
  logic [BYTE_W-1:0] byte_q;
  logic [ROW_W-1:0] row_q;
  logic ld_q, eol_q, r0_q, lr_q;

  wire eol  = byte_q == last_byte(act_w);
  wire lrow = row_q == last_row(act_h);

  assign col_load   = ld_q;
  assign col_data   = ld_q ? fb_rdata : 8'h00;
  assign row_clk    = ld_q & eol_q;
  assign frame_mark = row_clk & r0_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_w  <= 2'd0;
      pend_h  <= 2'd0;
      act_w   <= 2'd0;
      act_h   <= 2'd0;
      byte_q  <= '0;
      row_q   <= '0;
      fb_addr <= BASE;
      ld_q    <= 1'b0;
      eol_q   <= 1'b0;
      r0_q    <= 1'b0;
      lr_q    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (cfg_we) begin
        pend_w <= cfg_data[4:3];
        pend_h <= cfg_data[2:1];
      end
      ld_q  <= 1'b1;
      eol_q <= eol;
      r0_q  <= row_q == '0;
      lr_q  <= lrow;
      irq   <= (irq & ~irq_ack) | (row_clk & lr_q);
      if (eol) begin
        byte_q <= '0;
        if (lrow) begin
          row_q   <= '0;
          act_w   <= pend_w;
          act_h   <= pend_h;
          fb_addr <= BASE;
        end else begin
          row_q   <= row_q + 1'b1;
          fb_addr <= fb_addr + 1'b1;
        end
      end else begin
        byte_q  <= byte_q + 1'b1;
        fb_addr <= fb_addr + 1'b1;
      end
    end
  end

  a_r2_row_clk_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    row_clk |-> col_load);
  a_r5_mark_needs_row_clk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |-> row_clk);
  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (row_clk && lr_q) |=> irq);
  a_r4_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (row_clk && lr_q) |-> fb_addr == BASE);
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_load && !(row_clk && lr_q)) |-> fb_addr == $past(fb_addr) + 1'b1);

endmodule

// File: tb/lcd_scan_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_tb;
  localparam logic [15:0] BASE = 16'hC000;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, irq_ack = 1'b0;
  logic [7:0] cfg_data = 8'h00, fb_rdata = 8'h00;
  logic [15:0] fb_addr;
  logic [7:0] col_data;
  logic col_load, row_clk, frame_mark, irq;

  lcd_scan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .irq_ack(irq_ack), .fb_rdata(fb_rdata), .fb_addr(fb_addr),
    .col_data(col_data), .col_load(col_load), .row_clk(row_clk),
    .frame_mark(frame_mark), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] fbv(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]};
  endfunction
  function automatic int cb(input int s);
    case (s) 0: return 10; 1: return 12; 2: return 16; default: return 20; endcase
  endfunction
  function automatic int rn(input int s);
    case (s) 0: return 64; 1: return 32; 2: return 16; default: return 85; endcase
  endfunction

  always @(posedge clk) fb_rdata <= fbv(fb_addr);

  int errors = 0, checks = 0, cyc = 0, rc = 0, fm = 0;
  bit irq_prev = 0, rise = 0, done = 0;

  // reference model
  int m_byte, m_row, m_aw, m_ah, m_pw, m_ph;
  logic [15:0] m_addr = BASE;
  logic [7:0] m_data;
  bit m_ld, m_eol, m_r0, m_lr, m_irq;

  always @(posedge clk) begin : model
    bit e, l;
    if (!rst_n) begin
      m_byte = 0; m_row = 0; m_aw = 0; m_ah = 0; m_pw = 0; m_ph = 0;
      m_addr = BASE; m_ld = 0; m_eol = 0; m_r0 = 0; m_lr = 0; m_irq = 0;
    end else begin
      e = (m_byte == cb(m_aw) - 1);
      l = (m_row == rn(m_ah) - 1);
      m_irq = (m_irq && !irq_ack) || (m_ld && m_eol && m_lr);
      m_data = fbv(m_addr);
      m_ld = 1; m_eol = e; m_r0 = (m_row == 0); m_lr = l;
      if (e) begin
        m_byte = 0;
        if (l) begin m_row = 0; m_aw = m_pw; m_ah = m_ph; m_addr = BASE; end
        else begin m_row++; m_addr = m_addr + 16'd1; end
      end else begin
        m_byte++; m_addr = m_addr + 16'd1;
      end
      if (cfg_we) begin m_pw = int'(cfg_data[4:3]); m_ph = int'(cfg_data[2:1]); end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      chk(fb_addr == m_addr, "R3 fb_addr", int'(fb_addr), int'(m_addr));
      chk(col_load == m_ld, "R3 col_load", int'(col_load), int'(m_ld));
      if (m_ld) chk(col_data == m_data, "R3 col_data", int'(col_data), int'(m_data));
      chk(row_clk == (m_ld && m_eol), "R2 row_clk", int'(row_clk), int'(m_ld && m_eol));
      chk(frame_mark == (m_ld && m_eol && m_r0), "R5 frame_mark", int'(frame_mark),
          int'(m_ld && m_eol && m_r0));
      chk(irq == m_irq, "R6 irq", int'(irq), int'(m_irq));
    end
    rise = irq && !irq_prev;
    irq_prev = irq;
    if (row_clk) rc++;
    if (frame_mark) fm++;
    cfg_we = 1'b0;
    irq_ack = 1'b0;
  endtask

  task automatic wait_rise(output int at, input bit ack);
    for (int i = 0; i < 5000; i++) begin
      tick();
      if (rise) break;
    end
    at = cyc;
    if (ack) irq_ack = 1'b1;
  endtask

  int cur_w = 0, cur_h = 0;

  task automatic geo(input int w, input int h);
    int t0, t1, t2;
    wait_rise(t0, 1);
    repeat (37) tick();
    cfg_data = {3'b101, 2'(w), 2'(h), 1'b1};
    cfg_we = 1'b1;
    wait_rise(t1, 1);
    chk(t1 - t0 == cb(cur_w) * rn(cur_h), "R7 old geometry kept", t1 - t0,
        cb(cur_w) * rn(cur_h));
    rc = 0; fm = 0;
    wait_rise(t2, 1);
    chk(t2 - t1 == cb(w) * rn(h), "R8 irq period", t2 - t1, cb(w) * rn(h));
    chk(rc == rn(h), "R4 row clocks per frame", rc, rn(h));
    chk(fm == 1, "R5 frame marks per frame", fm, 1);
    cur_w = w; cur_h = h;
  endtask

  initial begin
    int t;
    repeat (3) tick();
    chk(fb_addr == BASE, "R1 reset fb_addr", int'(fb_addr), int'(BASE));
    chk(!col_load && !row_clk && !frame_mark, "R1 reset strobes",
        int'({col_load, row_clk, frame_mark}), 0);
    chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    geo(1, 1);
    geo(2, 2);
    geo(3, 3);
    geo(0, 0);
    geo(2, 1);
    // R6: flag held without ack, and set wins over a coinciding ack
    wait_rise(t, 0);
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (row_clk && m_lr) break;
    end
    chk(irq == 1'b1, "R6 flag held until ack", int'(irq), 1);
    irq_ack = 1'b1;
    tick();
    chk(irq == 1'b1, "R6 set wins over ack", int'(irq), 1);
    irq_ack = 1'b1;
    tick();
    tick();
    chk(irq == 1'b0, "R6 cleared by ack", int'(irq), 0);
    repeat (20) tick();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule